// File: doc/BRIEF.md
# UART transmitter with queued break and idle characters

The block serialises characters onto a single transmit line. It has three parts: a one-entry data holding register, a frame shift engine, and a small request queue for special characters. A normal character is a start bit of 0, then 8, 9 or 10 data bits sent least significant bit first, then one or two stop bits of 1. Every bit lasts one baud interval, which is the time from one `baud_tick` pulse to the next. A new character can only begin on a tick. A character can follow the previous one with no gap: it begins on the same tick that ends the last bit of the previous character.

Two special characters are supported. A break holds the line low for a full character time. An idle holds it high for a full character time. Software requests them through its control bits:

- A rising edge of `send_brk` queues a break.
- A falling edge of `tx_en` queues an idle.

A data word can also carry them in stream order. The word must have the marker bit 13 set and all of its active data bits equal to 0 (for a break) or all equal to 1 (for an idle). This lets a DMA stream insert them.

Clearing `tx_en` never cuts short the character on the line. It only stops the next character from starting. With the engine empty and `tx_en` low, the line rests high.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset `tx_out` is 1, `data_empty` is 1, and no break or idle request is pending.
- R2: A data character is a 0 start bit, then the data bits LSB first, then stop bits of 1. The data bits come from `data_in` bits 9..0. `fmt_len` selects the data length: 0 gives 8 bits, 1 gives 9 bits, 2 or 3 gives 10 bits. `two_stop`=1 gives two stop bits instead of one. Each bit is held for one baud interval.
- R3: A character is loaded only on a `baud_tick` cycle with `tx_en`=1, and only when the engine is empty or is ending its last bit on that tick. Back-to-back characters therefore leave no gap.
- R4: A rising edge of `send_brk` queues one break. A break drives 0 for 10 bit times with 8-bit data and one stop bit. It is one bit longer for 9-bit data, one bit longer for two stop bits, and 12 bits for any 10-bit format.
- R5: With `long_brk`=1 every break, whether requested or in-band, lasts 13 bit times.
- R6: If `send_brk` is still 1 on the tick that loads a requested break, one more break is queued.
- R7: A falling edge of `tx_en` queues one idle. Once `tx_en` is 1 again, the idle drives 1 for the normal character length: 1 + data bits + stop bits.
- R8: Clearing `tx_en` lets the character in progress finish in full. No further character starts while `tx_en` is 0, and the line then stays at 1.
- R9: A data word with bit 13 set is handled by looking at its active data bits. If they are all 0, a break is sent. If they are all 1, an idle is sent. Any other pattern is sent as normal data. Bits 12..10 have no effect.
- R10: When the engine loads, a requested break wins over a requested idle, and an idle wins over held data. Held data waits behind them with `data_empty` at 0.
- R11: A write with `data_wr` clears `data_empty` on the next cycle. `data_empty` returns to 1 on the cycle after the held word moves into the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| tx_en | input | 1 | Transmit enable level |
| send_brk | input | 1 | Break request level; a rising edge queues a break |
| long_brk | input | 1 | Stretch every break to 13 bit times |
| fmt_len | input | 2 | Data length select: 0 gives 8, 1 gives 9, 2 or 3 gives 10 |
| two_stop | input | 1 | Two stop bits when 1 |
| data_wr | input | 1 | Write strobe for the holding register |
| data_in | input | 14 | Bit 13 is the marker; bits 9..0 are data |
| tx_out | output | 1 | Serial transmit line |
| data_empty | output | 1 | Holding register empty flag |

## Verification
The properties take `baud_tick` to be a single-cycle pulse. They take `fmt_len`, `two_stop` and `long_brk` to be steady while a character is on the line or waiting. They take `data_wr` to be written only while `data_empty` is 1, because a write into a full register overwrites the held word. The stimulus respects all three. It changes the format only after the reference model reports the line quiet, with nothing queued. It writes a new word only after the model's holding register has drained. It toggles `tx_en` and `send_brk` as plain levels, sometimes in the middle of a character, so that edges land at any phase of the baud interval.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  localparam int DIN_W     = 14;
  localparam int MARK_BIT  = 13;
  localparam int DATA_MAX  = 10;
  localparam int FRAME_MAX = 13;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  typedef enum logic [1:0] {CH_NONE, CH_BRK, CH_IDLE, CH_DATA} char_kind_e;

  // number of data bits for a format code
  function automatic int data_bits(logic [1:0] fmt);
    case (fmt)
      2'd0:    return 8;
      2'd1:    return 9;
      default: return 10;
    endcase
  endfunction

  // mask of active data bits
  function automatic logic [DATA_MAX-1:0] data_mask(logic [1:0] fmt);
    return ~({DATA_MAX{1'b1}} << data_bits(fmt));
  endfunction

  // full character length in bit times
  function automatic logic [CNT_W-1:0] char_bits(logic [1:0] fmt, logic two_stop);
    return CNT_W'(1 + data_bits(fmt) + (two_stop ? 2 : 1));
  endfunction

  // break length in bit times
  function automatic logic [CNT_W-1:0] break_bits(logic [1:0] fmt, logic two_stop,
                                                  logic long_brk);
    int n;
    if (long_brk) n = 13;
    else if (fmt >= 2'd2) n = 12;
    else n = 10 + int'(fmt) + (two_stop ? 1 : 0);
    return CNT_W'(n);
  endfunction

  // start bit, data LSB first, everything above is stop level
  function automatic logic [FRAME_MAX-1:0] data_frame(logic [DATA_MAX-1:0] d,
                                                      logic [1:0] fmt);
    logic [FRAME_MAX-1:0] f;
    int nd;
    f    = '1;
    f[0] = 1'b0;
    nd   = data_bits(fmt);
    for (int i = 0; i < DATA_MAX; i++)
      if (i < nd) f[i+1] = d[i];
    return f;
  endfunction
endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg
  import uart_brk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic [DIN_W-1:0] data_in,
  input  logic             take_data,
  output logic [DIN_W-1:0] hold_q,
  output logic             full
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      full   <= 1'b0;
    end else if (data_wr) begin
      hold_q <= data_in;
      full   <= 1'b1;
    end else if (take_data) begin
      full   <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_req_queue.sv
module tx_req_queue (
  input  logic clk,
  input  logic rst_n,
  input  logic send_brk,
  input  logic tx_en,
  input  logic take_brk,
  input  logic take_idle,
  output logic brk_q,
  output logic idle_q
);
  logic prev_sb, prev_en;
  logic brk_rise, en_fall;

  assign brk_rise = send_brk & ~prev_sb;
  assign en_fall  = ~tx_en & prev_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sb <= 1'b0;
      prev_en <= 1'b0;
      brk_q   <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      prev_sb <= send_brk;
      prev_en <= tx_en;
      // a held request re-arms as the queued break leaves
      brk_q   <= brk_rise | (brk_q & ~take_brk) | (take_brk & send_brk);
      idle_q  <= en_fall | (idle_q & ~take_idle);
    end
  end
endmodule

// File: rtl/tx_shift_eng.sv
module tx_shift_eng
  import uart_brk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic                 load,
  input  char_kind_e           load_kind,
  input  logic [FRAME_MAX-1:0] load_frame,
  input  logic [CNT_W-1:0]     load_len,
  output logic                 tx_out,
  output logic                 active,
  output logic                 slot_free,
  output logic                 frame_end,
  output char_kind_e           cur_kind
);
  logic [FRAME_MAX-1:0] sreg;
  logic [CNT_W-1:0]     cnt;
  logic                 last_bit;

  assign last_bit  = (cnt == CNT_W'(1));
  assign slot_free = ~active | last_bit;
  assign frame_end = baud_tick & active & last_bit;
  assign tx_out    = active ? sreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg     <= '1;
      cnt      <= '0;
      active   <= 1'b0;
      cur_kind <= CH_NONE;
    end else if (baud_tick) begin
      if (active && !last_bit) begin
        sreg <= {1'b1, sreg[FRAME_MAX-1:1]};
        cnt  <= cnt - CNT_W'(1);
      end else if (load) begin
        sreg     <= load_frame;
        cnt      <= load_len;
        active   <= 1'b1;
        cur_kind <= load_kind;
      end else begin
        cnt      <= '0;
        active   <= 1'b0;
        cur_kind <= CH_NONE;
      end
    end
  end
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
  import uart_brk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             tx_en,
  input  logic             send_brk,
  input  logic             long_brk,
  input  logic [1:0]       fmt_len,
  input  logic             two_stop,
  input  logic             data_wr,
  input  logic [DIN_W-1:0] data_in,
  output logic             tx_out,
  output logic             data_empty
);
  logic [DIN_W-1:0]     hold_q;
  logic                 hold_full;
  logic                 brk_q, idle_q;
  logic                 shift_active, slot_free, frame_end;
  char_kind_e           cur_kind;
  logic                 can_load, load_brk, load_idle, load_data, load_any;
  logic [DATA_MAX-1:0]  hold_bits, act_mask;
  logic                 hold_is_brk, hold_is_idle;
  char_kind_e           ld_kind;
  logic [FRAME_MAX-1:0] ld_frame;
  logic [CNT_W-1:0]     ld_len;

  tx_hold_reg u_hold (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_in(data_in),
    .take_data(load_data), .hold_q(hold_q), .full(hold_full)
  );

  tx_req_queue u_req (
    .clk(clk), .rst_n(rst_n), .send_brk(send_brk), .tx_en(tx_en),
    .take_brk(load_brk), .take_idle(load_idle), .brk_q(brk_q), .idle_q(idle_q)
  );

  // load slot arbitration: requested break, then idle, then held data
  assign can_load  = baud_tick & slot_free & tx_en;
  assign load_brk  = can_load & brk_q;
  assign load_idle = can_load & ~brk_q & idle_q;
  assign load_data = can_load & ~brk_q & ~idle_q & hold_full;
  assign load_any  = load_brk | load_idle | load_data;

  // in-band marker classification, made at load time
  assign act_mask     = data_mask(fmt_len);
  assign hold_bits    = hold_q[DATA_MAX-1:0] & act_mask;
  assign hold_is_brk  = hold_q[MARK_BIT] & (hold_bits == '0);
  assign hold_is_idle = hold_q[MARK_BIT] & (hold_bits == act_mask);

  always_comb begin
    ld_kind  = CH_NONE;
    ld_frame = '1;
    ld_len   = '0;
    if (load_brk || (load_data && hold_is_brk)) begin
      ld_kind  = CH_BRK;
      ld_frame = '0;
      ld_len   = break_bits(fmt_len, two_stop, long_brk);
    end else if (load_idle || (load_data && hold_is_idle)) begin
      ld_kind  = CH_IDLE;
      ld_len   = char_bits(fmt_len, two_stop);
    end else if (load_data) begin
      ld_kind  = CH_DATA;
      ld_frame = data_frame(hold_q[DATA_MAX-1:0], fmt_len);
      ld_len   = char_bits(fmt_len, two_stop);
    end
  end

  tx_shift_eng u_shift (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load(load_any),
    .load_kind(ld_kind), .load_frame(ld_frame), .load_len(ld_len),
    .tx_out(tx_out), .active(shift_active), .slot_free(slot_free),
    .frame_end(frame_end), .cur_kind(cur_kind)
  );

  assign data_empty = ~hold_full;
endmodule

// File: rtl/uart_brk_tx_chk.sv
module uart_brk_tx_chk
  import uart_brk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             baud_tick,
  input logic             tx_en,
  input logic             send_brk,
  input logic             data_wr,
  input logic             tx_out,
  input logic             data_empty,
  input logic             shift_active,
  input logic             frame_end,
  input char_kind_e       cur_kind,
  input logic             load_brk,
  input logic             load_idle,
  input logic             load_data,
  input logic             brk_q,
  input logic             idle_q,
  input logic [DIN_W-1:0] hold_q
);
  // R3
  load_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_brk || load_idle || load_data) |-> (baud_tick && tx_en));
  // R3
  start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_active) |-> $past(baud_tick));
  // R8
  rest_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_active |-> tx_out);
  // R8
  no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_active && !frame_end) |=> shift_active);
  // R4
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_active && cur_kind == CH_BRK) |-> !tx_out);
  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_active && cur_kind == CH_IDLE) |-> tx_out);
  // R10
  one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_brk, load_idle, load_data}));
  // R10
  data_behind_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_data |-> (!brk_q && !idle_q));
  // R10
  idle_behind_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_idle |-> !brk_q);
  // R11
  empty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !data_empty);
  // R11
  empty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_data && !data_wr) |=> data_empty);
  // R11
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(hold_q));
  // R6
  requeue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_brk && send_brk) |=> brk_q);
  // R7
  idle_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |=> idle_q);
endmodule

bind uart_brk_tx uart_brk_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
  .send_brk(send_brk), .data_wr(data_wr), .tx_out(tx_out),
  .data_empty(data_empty), .shift_active(shift_active), .frame_end(frame_end),
  .cur_kind(cur_kind), .load_brk(load_brk), .load_idle(load_idle),
  .load_data(load_data), .brk_q(brk_q), .idle_q(idle_q), .hold_q(hold_q)
);

// File: tb/uart_brk_tx_bench.sv
`timescale 1ns/1ps
module uart_brk_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        tx_en = 1'b0, send_brk = 1'b0, long_brk = 1'b0, two_stop = 1'b0;
  logic [1:0]  fmt_len = 2'd0;
  logic        data_wr = 1'b0;
  logic [13:0] data_in = '0;
  logic        tx_out, data_empty;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";

  always #10 clk = ~clk;

  uart_brk_tx u_uart_brk_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(tick), .tx_en(tx_en),
    .send_brk(send_brk), .long_brk(long_brk), .fmt_len(fmt_len),
    .two_stop(two_stop), .data_wr(data_wr), .data_in(data_in),
    .tx_out(tx_out), .data_empty(data_empty)
  );

  // baud tick every fourth clock
  logic [1:0] div = '0;
  always @(posedge clk) begin
    if (!rst_n) begin div <= '0; tick <= 1'b0; end
    else begin div <= div + 2'd1; tick <= (div == 2'd3); end
  end

  // ---------------- reference model ----------------
  bit          mq[$];
  bit          m_brk, m_idle, m_full, p_en, p_sb;
  logic [13:0] m_hold;

  function automatic int m_dbits();
    return 8 + ((fmt_len > 2'd2) ? 2 : int'(fmt_len));
  endfunction
  function automatic int m_clen();
    return 1 + m_dbits() + (two_stop ? 2 : 1);
  endfunction
  function automatic int m_blen();
    if (long_brk) return 13;
    if (m_dbits() == 10) return 12;
    return m_dbits() + 2 + (two_stop ? 1 : 0);
  endfunction

  task automatic push_n(bit v, int n);
    for (int i = 0; i < n; i++) mq.push_back(v);
  endtask

  task automatic push_word(logic [13:0] w);
    int  nd;
    bit  zeros, ones;
    nd    = m_dbits();
    zeros = 1'b1;
    ones  = 1'b1;
    for (int i = 0; i < nd; i++) begin
      if (w[i]) zeros = 1'b0; else ones = 1'b0;
    end
    if (w[13] && zeros) push_n(1'b0, m_blen());
    else if (w[13] && ones) push_n(1'b1, m_clen());
    else begin
      mq.push_back(1'b0);
      for (int i = 0; i < nd; i++) mq.push_back(w[i]);
      push_n(1'b1, two_stop ? 2 : 1);
    end
  endtask

  always @(posedge clk) begin
    bit rise, fall, tb, ti, td;
    if (!rst_n) begin
      mq.delete();
      m_brk = 0; m_idle = 0; m_full = 0; p_en = 0; p_sb = 0; m_hold = '0;
    end else begin
      rise = send_brk && !p_sb;
      fall = !tx_en && p_en;
      tb = 0; ti = 0; td = 0;
      if (tick) begin
        if (mq.size() > 1) void'(mq.pop_front());
        else begin
          mq.delete();
          if (tx_en) begin
            if (m_brk) tb = 1;
            else if (m_idle) ti = 1;
            else if (m_full) td = 1;
          end
          if (tb) push_n(1'b0, m_blen());
          else if (ti) push_n(1'b1, m_clen());
          else if (td) push_word(m_hold);
        end
      end
      m_brk  = rise || (m_brk && !tb) || (tb && send_brk);
      m_idle = fall || (m_idle && !ti);
      if (data_wr) begin m_hold = data_in; m_full = 1; end
      else if (td) m_full = 0;
      p_en = tx_en;
      p_sb = send_brk;
    end
  end

  // compare every clock, half a period after the edge
  always @(negedge clk) begin
    bit exp_tx;
    if (rst_n) begin
      exp_tx = (mq.size() != 0) ? mq[0] : 1'b1;
      n_checks += 2;
      if (tx_out !== exp_tx) begin
        n_fail++;
        $display("FAIL %s tx_out act=%b exp=%b at %0t", cur_req, tx_out, exp_tx, $time);
      end
      if (data_empty !== !m_full) begin
        n_fail++;
        $display("FAIL R11 data_empty act=%b exp=%b at %0t", data_empty, !m_full, $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic write(logic [13:0] v);
    data_wr = 1'b1;
    data_in = v;
    step(1);
    data_wr = 1'b0;
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 4000 && m_full; i++) step(1);
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 8000; i++) begin
      if (mq.size() == 0 && !m_full && !m_brk && !m_idle) break;
      step(1);
    end
    step(8);
  endtask

  task automatic pulse_brk();
    send_brk = 1'b1;
    step(2);
    send_brk = 1'b0;
    wait_quiet();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    step(5);
    rst_n = 1'b1;
    step(1);
    @(negedge clk);
    // R1 reset state
    check(tx_out === 1'b1, "R1", "tx_out after reset", int'(tx_out), 1);
    check(data_empty === 1'b1, "R1", "data_empty after reset", int'(data_empty), 1);
    step(1);

    cur_req = "R2";
    tx_en = 1'b1;
    step(4);
    write(14'h00A5); wait_quiet();
    fmt_len = 2'd1; two_stop = 1'b1; write(14'h01C3); wait_quiet();
    fmt_len = 2'd2; two_stop = 1'b0; write(14'h02AA); wait_quiet();
    fmt_len = 2'd3; two_stop = 1'b1; write(14'h0155); wait_quiet();

    cur_req = "R3";
    fmt_len = 2'd0; two_stop = 1'b0;
    write(14'h003C); wait_empty();
    write(14'h0081); wait_empty();
    write(14'h007E); wait_quiet();

    cur_req = "R4";
    pulse_brk();
    fmt_len = 2'd1; two_stop = 1'b1; pulse_brk();
    fmt_len = 2'd2; two_stop = 1'b0; pulse_brk();
    fmt_len = 2'd0; two_stop = 1'b1; pulse_brk();
    fmt_len = 2'd1; two_stop = 1'b0; pulse_brk();

    cur_req = "R5";
    long_brk = 1'b1; fmt_len = 2'd0; two_stop = 1'b0; pulse_brk();
    fmt_len = 2'd2; two_stop = 1'b1; pulse_brk();
    write(14'h2000); wait_quiet();
    long_brk = 1'b0; fmt_len = 2'd0; two_stop = 1'b0;

    cur_req = "R6";
    send_brk = 1'b1;
    step(130);
    send_brk = 1'b0;
    wait_quiet();

    cur_req = "R7";
    write(14'h0055);
    step(9);
    tx_en = 1'b0; step(3); tx_en = 1'b1;
    wait_quiet();
    tx_en = 1'b0; step(2); tx_en = 1'b1;
    wait_quiet();

    cur_req = "R8";
    write(14'h000F);
    step(10);
    tx_en = 1'b0;
    step(150);
    write(14'h0033);
    step(60);
    @(negedge clk);
    // R8 no start while disabled, data held
    check(tx_out === 1'b1, "R8", "line while disabled", int'(tx_out), 1);
    check(data_empty === 1'b0, "R8", "data_empty while disabled", int'(data_empty), 0);
    step(1);
    tx_en = 1'b1;
    wait_quiet();

    cur_req = "R9";
    write(14'h2000); wait_quiet();
    write(14'h20FF); wait_quiet();
    write(14'h2012); wait_quiet();
    write(14'h3C00); wait_quiet();
    fmt_len = 2'd1;
    write(14'h21FF); wait_quiet();
    write(14'h20FF); wait_quiet();
    fmt_len = 2'd2;
    write(14'h23FF); wait_quiet();
    fmt_len = 2'd0;

    cur_req = "R10";
    tx_en = 1'b0;
    step(4);
    write(14'h0099);
    send_brk = 1'b1; step(2); send_brk = 1'b0;
    step(20);
    @(negedge clk);
    // R10 data waits behind the queued requests
    check(data_empty === 1'b0, "R10", "data_empty behind requests", int'(data_empty), 0);
    step(1);
    tx_en = 1'b1;
    wait_quiet();

    cur_req = "R11";
    tx_en = 1'b0;
    step(8);
    write(14'h0066);
    @(negedge clk);
    // R11 flag clears after a write
    check(data_empty === 1'b0, "R11", "data_empty after write", int'(data_empty), 0);
    step(1);
    tx_en = 1'b1;
    wait_quiet();
    @(negedge clk);
    // R11 flag set once the word has moved to the engine
    check(data_empty === 1'b1, "R11", "data_empty after load", int'(data_empty), 1);
    check(tx_out === 1'b1, "R11", "line at rest", int'(tx_out), 1);

    finish_run();
  end
endmodule